// File: doc/BRIEF.md
# Row-Streaming Adaptive Watermark Engine

The engine watermarks a grey-scale image that is streamed into it one full row per clock. It collects rows in bands of three. Each band is cut into 3×3 blocks, one block for each group of three adjacent columns. For every block, the engine counts how many of the nine pixels have their top bit set. A count of four, five or six marks the block as busy (disordered). Any other count marks it as smooth (ordered).

Each block takes one watermark bit. A busy block carries the bit in a higher bit plane and a smooth block carries it in a lower one. In the enhanced variant, the inverse of the watermark bit is also written into the bit plane just below.

All blocks of a band are handled in parallel. The watermarked rows leave the engine in their arrival order, one per clock, behind a fixed six-cycle fill. The engine raises a done flag once the last row of the image has been sent.

The engine is used as the pixel-path core of an image pass. A start pulse arms it and clears any partial state. The caller then presents `ROWS` rows with a valid strobe and may leave idle cycles between them. During each band, the caller also presents that band's watermark bits.

Top module: `wmk_row_engine`

## Requirements
- R1: After reset, `out_valid` and `done` are 0. A `start` pulse discards any rows already gathered and any band in flight. In the cycle after `start`, `out_valid` and `done` are 0.
- R2: A block is disordered exactly when the count of set top bits (bit `PIX_W-1`) over its nine pixels is 4, 5 or 6. Counts 0, 1, 2, 3, 7, 8 and 9 make it ordered.
- R3: In an ordered block, each pixel has bit `LO_POS` (default 2) replaced by the block's watermark bit w. With `ENHANCE`=1, bit `LO_POS-1` is also replaced by the inverse of w. All other bits are unchanged.
- R4: In a disordered block, each pixel has bit `HI_POS` (default 4) replaced by w. With `ENHANCE`=1, bit `HI_POS-1` is also replaced by the inverse of w. All other bits are unchanged.
- R5: With `ENHANCE`=0, only the single selected bit (`LO_POS` or `HI_POS`) is replaced and bits `LO_POS-1` and `HI_POS-1` keep their input values.
- R6: Pixel c of a row is `row_data[c*PIX_W +: PIX_W]`. Block b covers pixels 3b, 3b+1 and 3b+2 of the three rows of a band, and uses watermark bit `wm_bits[b]`. `wm_bits` is sampled only in the cycle in which the band's third row is accepted.
- R7: Output rows appear in input order, one per cycle, each marked by `out_valid`. When rows are presented on consecutive cycles, the cycle of the first accepted row is counted as 0. The row accepted in cycle k is then on `out_row` in cycle k+6.
- R8: `done` rises in the cycle after the last of the `ROWS` output rows, that is cycle `ROWS`+6 for a gap-free stream. It stays high with `out_valid` low until the next `start`.
- R9: Cycles with `row_valid` low pause row collection without losing or reordering data. The output data is the same as for a gap-free stream.
- R10: Rows are ignored before the first `start`, in the cycle `start` is high, and once `ROWS` rows have been accepted since the last `start`. Ignored rows produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms the engine and clears all band state and counters |
| row_valid | input | 1 | `row_data` holds an image row this cycle |
| row_data | input | COLS*PIX_W | One image row, pixel c at bits c*PIX_W upward |
| wm_bits | input | COLS/3 | Watermark bits of the current band, bit b for block b |
| out_row | output | COLS*PIX_W | Watermarked row |
| out_valid | output | 1 | `out_row` holds a watermarked row |
| done | output | 1 | All rows of the image have been sent |

## Verification
With a back-to-back stream, two events fall in the same cycle. One is the first row of the next band being written into the collector. The other is the finished band being copied into the classify stage. Likewise, the last row of one band leaves the output buffer in the same cycle the next embedded band is loaded into it. A gap-free random image provokes both, and each output row is judged against a per-block model, at the exact cycle k+6. A second case pulses `start` over a half-gathered band. A third interleaves idle cycles and trailing surplus rows. Both are judged on data, row count and the `done` flag.

// File: rtl/wmk_pkg.sv
// Shared definitions for the row-streaming watermark engine.
// Assumes 3x3 blocks; block kind is derived from the count of set top bits.
package wmk_pkg;
    localparam int unsigned BAND_ROWS = 3;
    localparam int unsigned BLK_COLS  = 3;
    localparam int unsigned BLK_PIX   = BAND_ROWS * BLK_COLS;

    typedef enum logic {
        BLK_ORDERED    = 1'b0,
        BLK_DISORDERED = 1'b1
    } blk_kind_t;

    // Busy blocks have a mid-range population of set top bits.
    function automatic blk_kind_t classify(input logic [3:0] msb_sum);
        return ((msb_sum >= 4'd4) && (msb_sum <= 4'd6)) ? BLK_DISORDERED : BLK_ORDERED;
    endfunction
endpackage

// File: rtl/wmk_band_collect.sv
// Gathers three accepted rows into a band buffer and pulses band_full for
// one cycle once the third row is in. The watermark bits are captured with
// the third row. Assumes ROWS is a multiple of 3; rows past ROWS are dropped.
module wmk_band_collect #(
    parameter int unsigned ROW_BITS = 48,
    parameter int unsigned NBLK     = 2,
    parameter int unsigned ROWS     = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     arm,
    input  logic                     row_valid,
    input  logic [ROW_BITS-1:0]      row_data,
    input  logic [NBLK-1:0]          wm_bits,
    output logic [2:0][ROW_BITS-1:0] band,
    output logic [NBLK-1:0]          band_wm,
    output logic                     band_full
);
    localparam int unsigned CNT_W = $clog2(ROWS + 1);

    logic [1:0]       slot;
    logic [CNT_W-1:0] in_cnt;
    logic             take;

    // A row is taken while armed and the image is not yet complete.
    assign take = arm && row_valid && (in_cnt < CNT_W'(ROWS));

    // Band buffer fill, row counting and band-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            band      <= '0;
            band_wm   <= '0;
            slot      <= '0;
            in_cnt    <= '0;
            band_full <= 1'b0;
        end else begin
            band_full <= 1'b0;
            if (take) begin
                band[slot] <= row_data;
                in_cnt     <= in_cnt + 1'b1;
                if (slot == 2'd2) begin
                    slot      <= '0;
                    band_wm   <= wm_bits;
                    band_full <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wmk_block_embed.sv
// One 3x3 block: stage 1 counts the top bits and registers the block kind
// with the pixels; stage 2 writes the watermark bit into the plane that the
// kind selects and registers the result. Pixel index is row*3 + column.
// Assumes 1 <= LO_POS < HI_POS < PIX_W-1 so the top bit is never touched.
module wmk_block_embed
    import wmk_pkg::*;
#(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned LO_POS  = 2,
    parameter int unsigned HI_POS  = 4,
    parameter bit          ENHANCE = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BLK_PIX-1:0][PIX_W-1:0] blk_pix,
    input  logic                         wm_bit,
    output logic [BLK_PIX-1:0][PIX_W-1:0] wm_pix
);
    logic [3:0]                    msb_sum;
    logic [BLK_PIX-1:0][PIX_W-1:0] s1_pix;
    logic                          s1_w;
    blk_kind_t                     s1_kind;
    logic [BLK_PIX-1:0][PIX_W-1:0] nxt;

    // Population count of the nine top bits.
    always_comb begin
        msb_sum = '0;
        for (int p = 0; p < int'(BLK_PIX); p++) begin
            msb_sum = msb_sum + 4'(blk_pix[p][PIX_W-1]);
        end
    end

    // Stage 1: register pixels, watermark bit and block kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_pix  <= '0;
            s1_w    <= 1'b0;
            s1_kind <= BLK_ORDERED;
        end else begin
            s1_pix  <= blk_pix;
            s1_w    <= wm_bit;
            s1_kind <= classify(msb_sum);
        end
    end

    generate
        if (ENHANCE) begin : g_enh
            // Embed w in the chosen plane and its inverse one plane lower.
            always_comb begin
                nxt = s1_pix;
                for (int p = 0; p < int'(BLK_PIX); p++) begin
                    if (s1_kind == BLK_DISORDERED) begin
                        nxt[p][HI_POS]   = s1_w;
                        nxt[p][HI_POS-1] = ~s1_w;
                    end else begin
                        nxt[p][LO_POS]   = s1_w;
                        nxt[p][LO_POS-1] = ~s1_w;
                    end
                end
            end
        end else begin : g_basic
            // Embed w in the chosen plane only.
            always_comb begin
                nxt = s1_pix;
                for (int p = 0; p < int'(BLK_PIX); p++) begin
                    if (s1_kind == BLK_DISORDERED) begin
                        nxt[p][HI_POS] = s1_w;
                    end else begin
                        nxt[p][LO_POS] = s1_w;
                    end
                end
            end
        end
    endgenerate

    // Stage 2: register the watermarked pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_pix <= '0;
        end else begin
            wm_pix <= nxt;
        end
    end
endmodule

// File: rtl/wmk_row_emit.sv
// Holds one watermarked band and sends its rows out in order, one per cycle.
// It counts the emitted rows and sets done after row ROWS-1. It assumes a
// new band is loaded no sooner than the cycle its last row is on the output.
module wmk_row_emit #(
    parameter int unsigned ROW_BITS = 48,
    parameter int unsigned ROWS     = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     load,
    input  logic [2:0][ROW_BITS-1:0] band,
    output logic [ROW_BITS-1:0]      out_row,
    output logic                     out_valid,
    output logic                     done
);
    localparam int unsigned CNT_W = $clog2(ROWS + 1);

    logic [2:0][ROW_BITS-1:0] hold;
    logic [1:0]               idx;
    logic                     act;
    logic [CNT_W-1:0]         out_cnt;

    // Band load, row stepping, row count and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hold    <= '0;
            idx     <= '0;
            act     <= 1'b0;
            out_cnt <= '0;
            done    <= 1'b0;
        end else begin
            if (load) begin
                hold <= band;
                idx  <= '0;
                act  <= 1'b1;
            end else if (act) begin
                if (idx == 2'd2) begin
                    act <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (act) begin
                out_cnt <= out_cnt + 1'b1;
                if (out_cnt == CNT_W'(ROWS - 1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    assign out_row   = hold[idx];
    assign out_valid = act;
endmodule

// File: rtl/wmk_row_engine.sv
// Top of the row-streaming watermark engine. Collects bands of three rows,
// runs COLS/3 block embedders in parallel over two register stages and
// replays the rows in order. Six cycles separate row input from row output.
// Assumes COLS and ROWS are multiples of 3.
module wmk_row_engine
    import wmk_pkg::*;
#(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned COLS    = 6,
    parameter int unsigned ROWS    = 9,
    parameter int unsigned LO_POS  = 2,
    parameter int unsigned HI_POS  = 4,
    parameter bit          ENHANCE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    row_valid,
    input  logic [COLS*PIX_W-1:0]   row_data,
    input  logic [COLS/3-1:0]       wm_bits,
    output logic [COLS*PIX_W-1:0]   out_row,
    output logic                    out_valid,
    output logic                    done
);
    localparam int unsigned ROW_BITS = COLS * PIX_W;
    localparam int unsigned NBLK     = COLS / BLK_COLS;

    logic                     running;
    logic                     s1_vld;
    logic                     s2_vld;
    logic [2:0][ROW_BITS-1:0] band;
    logic [NBLK-1:0]          band_wm;
    logic                     band_full;
    logic [2:0][ROW_BITS-1:0] emb;

    // Arm flag and band-valid tags that travel with the embed stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            s1_vld  <= 1'b0;
            s2_vld  <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            s1_vld  <= 1'b0;
            s2_vld  <= 1'b0;
        end else begin
            s1_vld <= band_full;
            s2_vld <= s1_vld;
        end
    end

    wmk_band_collect #(
        .ROW_BITS (ROW_BITS),
        .NBLK     (NBLK),
        .ROWS     (ROWS)
    ) i_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .arm       (running),
        .row_valid (row_valid),
        .row_data  (row_data),
        .wm_bits   (wm_bits),
        .band      (band),
        .band_wm   (band_wm),
        .band_full (band_full)
    );

    generate
        for (genvar b = 0; b < int'(NBLK); b++) begin : g_blk
            logic [BLK_PIX-1:0][PIX_W-1:0] pin;
            logic [BLK_PIX-1:0][PIX_W-1:0] pout;

            for (genvar r = 0; r < int'(BAND_ROWS); r++) begin : g_r
                for (genvar c = 0; c < int'(BLK_COLS); c++) begin : g_c
                    assign pin[r*BLK_COLS+c] = band[r][(b*BLK_COLS+c)*PIX_W +: PIX_W];
                    assign emb[r][(b*BLK_COLS+c)*PIX_W +: PIX_W] = pout[r*BLK_COLS+c];
                end
            end

            wmk_block_embed #(
                .PIX_W   (PIX_W),
                .LO_POS  (LO_POS),
                .HI_POS  (HI_POS),
                .ENHANCE (ENHANCE)
            ) i_embed (
                .clk     (clk),
                .rst_n   (rst_n),
                .blk_pix (pin),
                .wm_bit  (band_wm[b]),
                .wm_pix  (pout)
            );
        end
    endgenerate

    wmk_row_emit #(
        .ROW_BITS (ROW_BITS),
        .ROWS     (ROWS)
    ) i_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .load      (s2_vld),
        .band      (emb),
        .out_row   (out_row),
        .out_valid (out_valid),
        .done      (done)
    );
endmodule

// File: rtl/wmk_row_engine_chk.sv
// Protocol checks for the watermark engine, bound to every instance of the
// top module. Covers start clearing, done sequencing and band pacing.
module wmk_row_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic out_valid,
    input logic done,
    input logic band_ready
);
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!out_valid && !done)); // R1

    AST_DONE_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid)); // R8

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_BAND_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        band_ready |=> !band_ready); // R9
endmodule

bind wmk_row_engine wmk_row_engine_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .out_valid  (out_valid),
    .done       (done),
    .band_ready (s2_vld)
);

// File: tb/test_wmk_row_engine.sv
`timescale 1ns/1ps
module test_wmk_row_engine;
    localparam int PIX_W    = 8;
    localparam int COLS     = 6;
    localparam int ROWS     = 9;
    localparam int ROW_BITS = COLS * PIX_W;
    localparam int NBLK     = COLS / 3;
    localparam int NBAND    = ROWS / 3;
    localparam int LIMIT    = 48;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                row_valid = 1'b0;
    logic [ROW_BITS-1:0] row_data = '0;
    logic [NBLK-1:0]     wm_bits = '0;
    logic [ROW_BITS-1:0] out_row, out_row_b;
    logic                out_valid, out_valid_b, done, done_b;

    int n_chk = 0;
    int n_bad = 0;

    logic [ROW_BITS-1:0] img [ROWS];
    logic [NBLK-1:0]     wmv [NBAND];
    logic [ROW_BITS-1:0] cap [16];
    logic [ROW_BITS-1:0] cap_b [16];
    int                  cap_cyc [16];
    int                  cap_n;
    int                  done_cyc;

    always #2 clk = ~clk;

    wmk_row_engine #(.PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS), .ENHANCE(1'b1)) i_wmk_row_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .row_valid(row_valid),
        .row_data(row_data), .wm_bits(wm_bits),
        .out_row(out_row), .out_valid(out_valid), .done(done));

    wmk_row_engine #(.PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS), .ENHANCE(1'b0)) i_wmk_row_engine_basic (
        .clk(clk), .rst_n(rst_n), .start(start), .row_valid(row_valid),
        .row_data(row_data), .wm_bits(wm_bits),
        .out_row(out_row_b), .out_valid(out_valid_b), .done(done_b));

    initial begin
        #(4 * 4000);
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model of one output row, built per block from the rules.
    function automatic logic [ROW_BITS-1:0] exp_row(input int k, input bit enh);
        logic [ROW_BITS-1:0] res;
        int band;
        band = k / 3;
        res = img[k];
        for (int b = 0; b < NBLK; b++) begin
            int sum;
            bit dis;
            bit w;
            sum = 0;
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    sum += int'(img[band*3+r][(b*3+c)*PIX_W + PIX_W-1]);
            dis = (sum >= 4) && (sum <= 6);
            w = wmv[band][b];
            for (int c = 0; c < 3; c++) begin
                int base;
                base = (b*3+c)*PIX_W;
                if (dis) begin
                    res[base+4] = w;
                    if (enh) res[base+3] = ~w;
                end else begin
                    res[base+2] = w;
                    if (enh) res[base+1] = ~w;
                end
            end
        end
        return res;
    endfunction

    task automatic fill_random();
        for (int k = 0; k < ROWS; k++) img[k] = {$urandom, $urandom};
        for (int n = 0; n < NBAND; n++) wmv[n] = NBLK'($urandom);
    endtask

    // Pulse start (with a junk row that must be ignored) then stream the image,
    // sampling outputs at each falling edge before driving that cycle's inputs.
    task automatic stream(input int gap_every, input bit extra);
        int k;
        @(negedge clk);
        start = 1'b1; row_valid = 1'b1; row_data = {$urandom, $urandom};
        @(negedge clk);
        start = 1'b0;
        cap_n = 0; done_cyc = -1; k = 0;
        for (int t = 0; t < LIMIT; t++) begin
            if (t > 0) @(negedge clk);
            if (out_valid && cap_n < 16) begin
                cap[cap_n] = out_row; cap_b[cap_n] = out_row_b; cap_cyc[cap_n] = t; cap_n++;
            end
            if (done && done_cyc < 0) done_cyc = t;
            if (k < ROWS && !(gap_every != 0 && (t % gap_every) == gap_every - 1)) begin
                row_valid = 1'b1; row_data = img[k];
                wm_bits = ((k % 3) == 2) ? wmv[k/3] : ~wmv[k/3];
                k++;
            end else if (k >= ROWS && extra) begin
                row_valid = 1'b1; row_data = {$urandom, $urandom}; wm_bits = NBLK'($urandom);
            end else begin
                row_valid = 1'b0; row_data = {$urandom, $urandom}; wm_bits = NBLK'($urandom);
            end
        end
        row_valid = 1'b0;
    endtask

    task automatic check_rows(input string req, input bit timed);
        chk(cap_n == ROWS, req, "row count", 64'(cap_n), 64'(ROWS));
        for (int k = 0; k < ROWS && k < cap_n; k++) begin
            chk(cap[k] == exp_row(k, 1'b1), req, $sformatf("row %0d data", k),
                64'(cap[k]), 64'(exp_row(k, 1'b1)));
            chk(cap_b[k] == exp_row(k, 1'b0), "R5", $sformatf("basic row %0d data", k),
                64'(cap_b[k]), 64'(exp_row(k, 1'b0)));
            if (timed)
                chk(cap_cyc[k] == k + 6, "R7", $sformatf("row %0d cycle", k),
                    64'(cap_cyc[k]), 64'(k + 6));
        end
        if (timed)
            chk(done_cyc == ROWS + 6, "R8", "done cycle", 64'(done_cyc), 64'(ROWS + 6));
        else
            chk(done_cyc > 0, "R8", "done seen", 64'(done_cyc), 64'(1));
        chk(done == 1'b1 && out_valid == 1'b0, "R8", "done held, no output",
            64'({done, out_valid}), 64'(2'b10));
    endtask

    task automatic t_reset_and_prestart();
        int seen;
        chk(out_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
            64'({out_valid, done}), 64'(0));
        seen = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (out_valid || out_valid_b) seen++;
            row_valid = (t < 12); row_data = {$urandom, $urandom}; wm_bits = NBLK'($urandom);
        end
        row_valid = 1'b0;
        chk(seen == 0, "R10", "rows before start give no output", 64'(seen), 64'(0));
    endtask

    task automatic t_random_back_to_back();
        fill_random();
        stream(0, 1'b0);
        check_rows("R6", 1'b1);
    endtask

    task automatic t_class_edges();
        int sums [6] = '{3, 4, 6, 7, 0, 9};
        for (int n = 0; n < NBAND; n++) begin
            for (int r = 0; r < 3; r++) begin
                logic [ROW_BITS-1:0] row;
                row = {$urandom, $urandom};
                for (int b = 0; b < NBLK; b++)
                    for (int c = 0; c < 3; c++)
                        row[(b*3+c)*PIX_W + PIX_W-1] = ((r*3 + c) < sums[n*NBLK + b]);
                img[n*3+r] = row;
            end
            wmv[n] = NBLK'($urandom);
        end
        stream(0, 1'b0);
        check_rows("R2", 1'b1);
        // Bits 4..1 of pixel 0 of block 0 and block 1, band 0 (sums 3 and 4).
        chk(cap[0][4:1] == {img[0][4:3], wmv[0][0], ~wmv[0][0]}, "R3", "ordered planes",
            64'(cap[0][4:1]), 64'({img[0][4:3], wmv[0][0], ~wmv[0][0]}));
        chk(cap[0][28:25] == {wmv[0][1], ~wmv[0][1], img[0][26:25]}, "R4", "disordered planes",
            64'(cap[0][28:25]), 64'({wmv[0][1], ~wmv[0][1], img[0][26:25]}));
    endtask

    task automatic t_start_flush();
        fill_random();
        @(negedge clk);
        start = 1'b1; row_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 2; t++) begin
            row_valid = 1'b1; row_data = {$urandom, $urandom};
            @(negedge clk);
        end
        row_valid = 1'b0;
        stream(0, 1'b0);
        check_rows("R1", 1'b1);
    endtask

    task automatic t_gaps_and_surplus();
        fill_random();
        stream(3, 1'b1);
        check_rows("R9", 1'b0);
        chk(cap_n == ROWS, "R10", "surplus rows ignored", 64'(cap_n), 64'(ROWS));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_prestart();
        t_random_back_to_back();
        t_class_edges();
        t_start_flush();
        t_gaps_and_surplus();
        t_random_back_to_back();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule